// File: doc/BRIEF.md
# MDIO Single-Access Management Controller

This block lets a processor run one Clause 22 management transaction at a time on an MDC/MDIO serial bus to an external PHY. Software works through two 32-bit registers. The command word holds a start/busy flag, a two-bit operation selector, the low two bits of the PHY address and a five-bit register index. The data word carries the outgoing value in its low half and the value returned by the most recent read in its high half.

To start a transfer, software writes the command word with the start flag set. The controller generates MDC by dividing the system clock, shifts out the whole frame on MDIO, and either drives the write data or releases the line and collects the PHY's reply. It clears the start flag when the frame ends, so software polls that flag until it reads 0. The upper three PHY address bits are always sent as zero.

Top module: `mdio_single_ctrl`

## Requirements
- R1: Writing the command word (bus_sel=0) with bit 20 set and a valid operation code starts one frame. Bit 20 reads 1 while the frame runs and returns to 0 on its own after the last data bit.
- R2: A frame consists of 64 bits sent most significant first: 32 ones, the start pattern 01, the operation code (01 for write, 10 for read), 000, PHY address bits 1:0 taken from command bits 9:8, the register index from command bits 4:0, two turnaround bits, and 16 data bits.
- R3: On a write, the controller drives the turnaround as 1 then 0, followed by data-word bits 15:0, and keeps MDIO driven for all 64 bits.
- R4: On a read, the controller releases MDIO (mdio_oe=0) from the first turnaround bit to the end of the frame. It samples mdio_in on the 16 rising MDC edges of the data phase and places the result in data-word bits 31:16.
- R5: The command word resets to 0x00010000. Its fields are start at bit 20, operation code at bits 17:16, PHY address at bits 9:8 and register index at bits 4:0. All other bits read as 0 whatever was written to them.
- R6: The data word resets to 0. Bits 15:0 are written through bus_sel=1. Bits 31:16 ignore bus writes and change only when a read frame completes.
- R7: A start with operation code 00 or 11 produces no MDC pulse and does not drive MDIO. Bit 20 clears within 4 clock cycles.
- R8: While bit 20 is 1, bus writes to the command word and to data bits 15:0 have no effect.
- R9: An MDC period lasts 2*HALF_DIV system clocks. MDC stays low and MDIO stays released while idle. MDIO changes only at the clock edge on which MDC falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_sel | input | 1 | 0 selects the command word, 1 selects the data word |
| bus_wdata | input | 32 | Register write data |
| cmd_word | output | 32 | Current command word |
| data_word | output | 32 | Current data word |
| mdc | output | 1 | Management clock to the PHY |
| mdio_in | input | 1 | MDIO level as seen at the pad |
| mdio_out | output | 1 | MDIO value driven by the controller |
| mdio_oe | output | 1 | MDIO output enable |

## Verification
A write frame to PHY 2, register 5 with data 0xA5C3 checks every driven bit against a frame built from the field rules, including the 10 turnaround. A read frame to PHY 3, register 31, answered by a modelled PHY with 0x1234, separates the release window from the driven window and shows where the captured bits land. Command and data writes issued in the middle of a frame, and starts with both reserved codes, show whether the busy flag blocks updates and whether a bad code could leak onto the bus. An all-ones write with the start bit clear confirms that the reserved bits stay zero.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int FRAME_BITS = 64;
  localparam int DATA_BITS  = 16;
  localparam int TA_FIRST   = 46;
  localparam int DATA_FIRST = FRAME_BITS - DATA_BITS;
  localparam int IDX_W      = $clog2(FRAME_BITS);

  localparam logic [1:0] OP_WRITE = 2'b01;
  localparam logic [1:0] OP_READ  = 2'b10;

  localparam int GO_BIT = 20;

  typedef enum logic [0:0] {SEQ_IDLE = 1'b0, SEQ_RUN = 1'b1} seq_state_e;

  typedef struct packed {
    logic [1:0] op;
    logic [1:0] phy;
    logic [4:0] regad;
  } mgmt_cmd_t;
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
  parameter int HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic mdc,
  output logic rise_tick,
  output logic fall_tick
);
  localparam int CW = $clog2(HALF_DIV + 1);
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          mdc_q, mdc_d;
  logic          wrap;

  assign wrap      = run && (cnt_q == LAST);
  assign rise_tick = wrap && !mdc_q;
  assign fall_tick = wrap && mdc_q;
  assign mdc       = mdc_q;

  always_comb begin
    cnt_d = cnt_q;
    mdc_d = mdc_q;
    if (!run) begin
      cnt_d = '0;
      mdc_d = 1'b0;
    end else if (wrap) begin
      cnt_d = '0;
      mdc_d = !mdc_q;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      mdc_q <= mdc_d;
    end
  end
endmodule

// File: rtl/mdio_regs.sv
module mdio_regs
  import mdio_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic        bus_sel,
  input  logic [31:0] bus_wdata,
  input  logic        seq_done,
  input  logic        rd_valid,
  input  logic [DATA_BITS-1:0] rd_value,
  output logic        go,
  output logic        start,
  output mgmt_cmd_t   cmd,
  output logic [DATA_BITS-1:0] wr_value,
  output logic [31:0] cmd_word,
  output logic [31:0] data_word
);
  logic                 go_q, go_d;
  logic                 start_q, start_d;
  mgmt_cmd_t            cmd_q, cmd_d;
  logic [DATA_BITS-1:0] wv_q, wv_d;
  logic [DATA_BITS-1:0] rv_q, rv_d;
  logic                 cmd_we, dat_we;

  assign cmd_we = bus_wr && !bus_sel && !go_q;
  assign dat_we = bus_wr &&  bus_sel && !go_q;

  always_comb begin
    go_d    = go_q;
    start_d = 1'b0;
    cmd_d   = cmd_q;
    wv_d    = wv_q;
    rv_d    = rv_q;
    if (cmd_we) begin
      cmd_d.op    = bus_wdata[17:16];
      cmd_d.phy   = bus_wdata[9:8];
      cmd_d.regad = bus_wdata[4:0];
      go_d        = bus_wdata[GO_BIT];
      start_d     = bus_wdata[GO_BIT];
    end
    if (dat_we) begin
      wv_d = bus_wdata[DATA_BITS-1:0];
    end
    if (seq_done) begin
      go_d = 1'b0;
    end
    if (rd_valid) begin
      rv_d = rd_value;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      go_q    <= 1'b0;
      start_q <= 1'b0;
      cmd_q   <= '{op: OP_WRITE, phy: 2'b00, regad: 5'd0};
      wv_q    <= '0;
      rv_q    <= '0;
    end else begin
      go_q    <= go_d;
      start_q <= start_d;
      cmd_q   <= cmd_d;
      wv_q    <= wv_d;
      rv_q    <= rv_d;
    end
  end

  assign go        = go_q;
  assign start     = start_q;
  assign cmd       = cmd_q;
  assign wr_value  = wv_q;
  assign cmd_word  = {11'd0, go_q, 2'b00, cmd_q.op, 6'd0, cmd_q.phy, 3'd0, cmd_q.regad};
  assign data_word = {rv_q, wv_q};
endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
  import mdio_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  mgmt_cmd_t   cmd,
  input  logic [DATA_BITS-1:0] wr_value,
  input  logic        rise_tick,
  input  logic        fall_tick,
  input  logic        mdio_in,
  output logic        run,
  output logic        mdio_out,
  output logic        mdio_oe,
  output logic        done,
  output logic        rd_valid,
  output logic [DATA_BITS-1:0] rd_value
);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(FRAME_BITS - 1);
  localparam logic [IDX_W-1:0] IDX_TA   = IDX_W'(TA_FIRST);
  localparam logic [IDX_W-1:0] IDX_DATA = IDX_W'(DATA_FIRST);

  seq_state_e             st_q, st_d;
  logic [FRAME_BITS-1:0]  sh_q, sh_d;
  logic [IDX_W-1:0]       idx_q, idx_d;
  logic                   rd_q, rd_d;
  logic                   oe_q, oe_d;
  logic                   done_q, done_d;
  logic                   rv_q, rv_d;
  logic [DATA_BITS-1:0]   cap_q, cap_d;
  logic                   op_ok;
  logic [1:0]             ta_bits;
  logic [FRAME_BITS-1:0]  frame;

  assign op_ok   = (cmd.op == OP_WRITE) || (cmd.op == OP_READ);
  assign ta_bits = (cmd.op == OP_WRITE) ? 2'b10 : 2'b00;
  assign frame   = {32'hFFFF_FFFF, 2'b01, cmd.op, 3'b000, cmd.phy, cmd.regad,
                    ta_bits, wr_value};

  always_comb begin
    st_d   = st_q;
    sh_d   = sh_q;
    idx_d  = idx_q;
    rd_d   = rd_q;
    oe_d   = oe_q;
    done_d = 1'b0;
    rv_d   = 1'b0;
    cap_d  = cap_q;
    case (st_q)
      SEQ_IDLE: begin
        if (start) begin
          if (op_ok) begin
            st_d  = SEQ_RUN;
            sh_d  = frame;
            idx_d = '0;
            rd_d  = (cmd.op == OP_READ);
            oe_d  = 1'b1;
          end else begin
            done_d = 1'b1;
          end
        end
      end
      SEQ_RUN: begin
        if (rise_tick && rd_q && (idx_q >= IDX_DATA)) begin
          cap_d = {cap_q[DATA_BITS-2:0], mdio_in};
        end
        if (fall_tick) begin
          if (idx_q == IDX_LAST) begin
            st_d   = SEQ_IDLE;
            oe_d   = 1'b0;
            done_d = 1'b1;
            rv_d   = rd_q;
          end else begin
            idx_d = idx_q + 1'b1;
            sh_d  = {sh_q[FRAME_BITS-2:0], 1'b0};
            oe_d  = !(rd_q && ((idx_q + 1'b1) >= IDX_TA));
          end
        end
      end
      default: st_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SEQ_IDLE;
      sh_q   <= '0;
      idx_q  <= '0;
      rd_q   <= 1'b0;
      oe_q   <= 1'b0;
      done_q <= 1'b0;
      rv_q   <= 1'b0;
      cap_q  <= '0;
    end else begin
      st_q   <= st_d;
      sh_q   <= sh_d;
      idx_q  <= idx_d;
      rd_q   <= rd_d;
      oe_q   <= oe_d;
      done_q <= done_d;
      rv_q   <= rv_d;
      cap_q  <= cap_d;
    end
  end

  assign run      = (st_q == SEQ_RUN);
  assign mdio_out = sh_q[FRAME_BITS-1];
  assign mdio_oe  = oe_q;
  assign done     = done_q;
  assign rd_valid = rv_q;
  assign rd_value = cap_q;
endmodule

// File: rtl/mdio_single_ctrl.sv
module mdio_single_ctrl
  import mdio_pkg::*;
#(
  parameter int HALF_DIV = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic        bus_sel,
  input  logic [31:0] bus_wdata,
  output logic [31:0] cmd_word,
  output logic [31:0] data_word,
  output logic        mdc,
  input  logic        mdio_in,
  output logic        mdio_out,
  output logic        mdio_oe
);
  logic [1:0] rst_sync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  logic                 go, start, seq_done, rd_valid, run;
  logic                 rise_tick, fall_tick;
  mgmt_cmd_t            cmd;
  logic [DATA_BITS-1:0] wr_value, rd_value;

  mdio_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .bus_wr    (bus_wr),
    .bus_sel   (bus_sel),
    .bus_wdata (bus_wdata),
    .seq_done  (seq_done),
    .rd_valid  (rd_valid),
    .rd_value  (rd_value),
    .go        (go),
    .start     (start),
    .cmd       (cmd),
    .wr_value  (wr_value),
    .cmd_word  (cmd_word),
    .data_word (data_word)
  );

  mdio_clkgen #(.HALF_DIV(HALF_DIV)) u_clk (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .run       (run),
    .mdc       (mdc),
    .rise_tick (rise_tick),
    .fall_tick (fall_tick)
  );

  mdio_frame_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .start     (start && go),
    .cmd       (cmd),
    .wr_value  (wr_value),
    .rise_tick (rise_tick),
    .fall_tick (fall_tick),
    .mdio_in   (mdio_in),
    .run       (run),
    .mdio_out  (mdio_out),
    .mdio_oe   (mdio_oe),
    .done      (seq_done),
    .rd_valid  (rd_valid),
    .rd_value  (rd_value)
  );
endmodule

// File: rtl/mdio_single_ctrl_chk.sv
module mdio_single_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        mdc,
  input logic        mdio_out,
  input logic        mdio_oe,
  input logic [31:0] cmd_word,
  input logic [31:0] data_word
);
  // R9
  mdio_steady_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mdc && $past(mdc)) |-> ($stable(mdio_out) && $stable(mdio_oe)));

  // R9
  mdio_steady_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mdc) |-> ($stable(mdio_out) && $stable(mdio_oe)));

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_word[20] |-> (!mdio_oe && !mdc));

  // R7
  rsv_op_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_word[20] && (cmd_word[17:16] == 2'b00 || cmd_word[17:16] == 2'b11))
      |-> (!mdio_oe && !mdc));

  // R8
  busy_cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_word[20] && $past(cmd_word[20])) |-> $stable(cmd_word[17:0]));

  // R8
  busy_wdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_word[20] && $past(cmd_word[20])) |-> $stable(data_word[15:0]));

  // R5
  rsv_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_word[31:21] == 11'd0) && (cmd_word[19:18] == 2'b00) &&
    (cmd_word[15:10] == 6'd0) && (cmd_word[7:5] == 3'd0));
endmodule

bind mdio_single_ctrl mdio_single_ctrl_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mdc       (mdc),
  .mdio_out  (mdio_out),
  .mdio_oe   (mdio_oe),
  .cmd_word  (cmd_word),
  .data_word (data_word)
);

// File: tb/mdio_single_ctrl_test.sv
`timescale 1ns/1ps
module mdio_single_ctrl_test;
  localparam int HALF_DIV = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_sel = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] cmd_word, data_word;
  logic        mdc, mdio_in, mdio_out, mdio_oe;

  always #4 clk = !clk;

  mdio_single_ctrl #(.HALF_DIV(HALF_DIV)) uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_sel(bus_sel),
    .bus_wdata(bus_wdata), .cmd_word(cmd_word), .data_word(data_word),
    .mdc(mdc), .mdio_in(mdio_in), .mdio_out(mdio_out), .mdio_oe(mdio_oe)
  );

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic [63:0] bits;
    logic [63:0] mask;
    string       tag;
  } frame_t;

  frame_t      exp_q[$];
  logic [15:0] phy_val = 16'h0;
  int          rise_total = 0;
  int          frames_seen = 0;
  bit          period_done = 0;

  task automatic check(input bit ok, input string req, input logic [63:0] got,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic cpu_write(input bit sel, input logic [31:0] val);
    @(negedge clk);
    bus_wr = 1'b1; bus_sel = sel; bus_wdata = val;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (cmd_word[20]);
    @(negedge clk);
  endtask

  // Driver: builds the expected frame, queues it and issues the command.
  task automatic send_cmd(input logic [1:0] op, input logic [1:0] phy,
                          input logic [4:0] ra, input logic [15:0] wd,
                          input string tag);
    frame_t f;
    f.bits = {32'hFFFF_FFFF, 2'b01, op, 3'b000, phy, ra, 2'b10, wd};
    f.mask = (op == 2'b10) ? {{46{1'b1}}, 18'd0} : {64{1'b1}};
    f.tag  = tag;
    exp_q.push_back(f);
    cpu_write(1'b0, {11'd0, 1'b1, 2'b00, op, 6'd0, phy, 3'd0, ra});
  endtask

  // Monitor and PHY model: collect bits on MDC rises, answer reads.
  initial begin
    logic [63:0] got_b, got_m;
    int   cnt = 0;
    logic prev = 1'b0;
    int   cyc = 0;
    int   last_rise = -1;
    mdio_in = 1'b1;
    forever begin
      @(negedge clk);
      cyc++;
      if (mdc && !prev) begin
        rise_total++;
        got_b[63-cnt] = mdio_out;
        got_m[63-cnt] = mdio_oe;
        if (last_rise >= 0 && !period_done) begin
          // R9 MDC period equals twice the half divider
          check((cyc - last_rise) == 2*HALF_DIV, "R9 mdc period",
                64'(cyc - last_rise), 64'(2*HALF_DIV));
          period_done = 1;
        end
        last_rise = cyc;
        cnt++;
        if (cnt == 64) begin
          frame_t f;
          cnt = 0;
          frames_seen++;
          if (exp_q.size() == 0) begin
            check(0, "R8 unexpected frame", got_b, 64'd0);
          end else begin
            f = exp_q.pop_front();
            check(got_m == f.mask, {f.tag, " oe"}, got_m, f.mask);
            check(((got_b ^ f.bits) & f.mask) == 64'd0, {f.tag, " bits"},
                  got_b & f.mask, f.bits & f.mask);
          end
        end
      end
      prev = mdc;
      mdio_in = (cnt >= 48) ? phy_val[63-cnt] : 1'b1;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int rises0;
    int waited;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R5 reset value of command word
    check(cmd_word == 32'h0001_0000, "R5 cmd reset", 64'(cmd_word), 64'h0001_0000);
    // R6 reset value of data word
    check(data_word == 32'h0, "R6 data reset", 64'(data_word), 64'h0);
    // R9 idle bus
    check(!mdc && !mdio_oe, "R9 idle", {62'd0, mdc, mdio_oe}, 64'd0);

    // R5 reserved bits read as zero
    cpu_write(1'b0, 32'hFFEF_FFFF);
    @(negedge clk);
    check(cmd_word == 32'h0003_031F, "R5 reserved zero", 64'(cmd_word), 64'h0003_031F);

    // R6 upper half of data word ignores bus writes
    cpu_write(1'b1, 32'hBEEF_A5C3);
    @(negedge clk);
    check(data_word == 32'h0000_A5C3, "R6 rdata read-only", 64'(data_word), 64'h0000_A5C3);

    // R1 R2 R3 write frame; R8 writes during busy ignored
    send_cmd(2'b01, 2'd2, 5'd5, 16'hA5C3, "R3 write frame");
    @(negedge clk);
    check(cmd_word[20] == 1'b1, "R1 busy set", 64'(cmd_word[20]), 64'd1);
    repeat (20) @(negedge clk);
    cpu_write(1'b0, 32'h0012_0107);
    cpu_write(1'b1, 32'h0000_1111);
    wait_idle();
    check(cmd_word == 32'h0001_0205, "R8 cmd unchanged", 64'(cmd_word), 64'h0001_0205);
    check(data_word == 32'h0000_A5C3, "R8 wdata unchanged", 64'(data_word), 64'h0000_A5C3);
    check(frames_seen == 1, "R1 one frame", 64'(frames_seen), 64'd1);

    // R2 R4 read frame from PHY 3 register 31
    phy_val = 16'h1234;
    send_cmd(2'b10, 2'd3, 5'd31, 16'hA5C3, "R4 read frame");
    wait_idle();
    check(data_word == 32'h1234_A5C3, "R4 read data", 64'(data_word), 64'h1234_A5C3);
    check(cmd_word == 32'h0002_031F, "R1 go cleared", 64'(cmd_word), 64'h0002_031F);

    // R6 a write frame leaves read data alone
    send_cmd(2'b01, 2'd1, 5'd0, 16'hA5C3, "R2 write frame 2");
    wait_idle();
    check(data_word == 32'h1234_A5C3, "R6 rdata held", 64'(data_word), 64'h1234_A5C3);

    // R7 reserved operation codes
    for (int k = 0; k < 2; k++) begin
      rises0 = rise_total;
      cpu_write(1'b0, (k == 0) ? 32'h0010_0101 : 32'h0013_0101);
      waited = 0;
      while (cmd_word[20] && waited < 10) begin
        @(negedge clk);
        waited++;
      end
      check(waited <= 4, "R7 go cleared", 64'(waited), 64'd4);
      repeat (20) @(negedge clk);
      check(rise_total == rises0, "R7 no mdc", 64'(rise_total), 64'(rises0));
    end
    check(exp_q.size() == 0, "R2 all frames seen", 64'(exp_q.size()), 64'd0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule